// File: doc/BRIEF.md
# Buffered Capture/Compare Timer Channel

This block is one 16-bit timer channel with four general registers, named A to D. Each register works either as a compare register or as a capture register. As a compare register it drives its own waveform output when the counter equals its value. As a capture register it latches the counter when a chosen edge appears on its own capture input. The counter advances on one of eight prescaled ticks, taken from the system clock divided by 1, 2, 4, and so on up to 128. A selected register event can clear the counter back to zero.

Register C can act as a buffer for register A, and register D as a buffer for register B. In a buffered pair a capture is double-buffered, so the older captured value moves into the buffer register. In a buffered compare pair the compare value reloads from the buffer on each match, so software can change the compare value at any time without glitches. A PWM mode uses register A as the period. The other three registers then set the duty of outputs 1 to 3.

All configuration, the counter, the status flags and the general registers are reached through a simple single-cycle register port. A write takes effect on the clock edge at which `bus_we` is sampled high. Reads are combinational.

Top module: `bct_timer`

## Requirements
- R1: After reset the counter, all four general registers, the control word (address 0), the mode word (address 1), the status flags (address 3) and all four waveform outputs read as zero.
- R2: When the run bit (control bit 9) is set and the clock-select field (control bits 2:0) is s, the counter increases by exactly one every 2^s clock cycles. While the run bit is clear the counter holds. A write to address 2 loads the counter directly.
- R3: For register i in compare mode, a tick at which the counter equals the register sets status bit i. The 2-bit output mode in bits 4i+1:4i of the mode word then acts on output i: 0 leaves it, 1 drives it low, 2 drives it high, 3 toggles it.
- R4: Mode-word bit 4i+3 set puts register i in capture mode. The edge field in bits 4i+1:4i selects the edge: 1 rising, 2 falling, 3 both, 0 none. An edge of any other kind is ignored. The capture input passes through two synchronizing flops before edge detection.
- R5: A capture loads the register with the counter value and sets status bit i.
- R6: A tick at which the counter wraps from 0xFFFF to 0x0000 sets status bit 4.
- R7: The clear-source field (control bits 5:3) value k from 1 to 4 selects register k-1 (A..D). An event of that register, whether a match or a capture, makes the counter 0 on the next edge instead of advancing it. Value 0 never clears the counter.
- R8: Writing 1 to a status bit at address 3 clears it, and writing 0 leaves it. An event in the same cycle as the write wins.
- R9: With control bit 6 set (A/C paired) and A capturing, each capture copies A's old value into C while A takes the counter. Control bit 7 does the same for B and D.
- R10: With a pair enabled and A (or B) in compare mode, each match reloads A (or B) from C (or D).
- R11: With control bit 8 set, all active registers compare, register A sets the period by clearing the counter on its match, and output 0 stays low. Output i (1..3) goes high on the period match and low on its own match. With period P+1 and duty value d < P, the output is high for d+1 of every P+1 ticks.
- R12: Addresses 4 to 7 read and write registers A to D. A bus write wins over a hardware update of the same register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address (0 control, 1 mode, 2 counter, 3 status, 4-7 registers A-D) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| cap_in | input | 4 | Asynchronous capture inputs, one per register |
| wave_out | output | 4 | Waveform outputs, one per register |

## Verification
On every cycle the assertions check the following. A selected clear event zeroes the counter. A wrap sets the overflow flag. A capture lands the counter value in register A. A buffered capture shifts A into C, and a buffered match reloads A from C. Output 0 stays low in PWM mode. The bench's scenarios show what only a sequence of stimuli can reveal: the tick rate for each prescaler setting, the action of each output mode, edge selection that ignores the wrong edge, write-one-to-clear on the flags, and the measured PWM duty over whole periods.

// File: rtl/bct_pkg.sv
package bct_pkg;
    localparam int CNT_W  = 16;
    localparam int NREG   = 4;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 3;
    localparam int DIV_W  = (1 << SEL_W) - 1;

    typedef struct packed {
        logic             run;
        logic             pwm;
        logic             buf_bd;
        logic             buf_ac;
        logic [2:0]       clr_src;
        logic [SEL_W-1:0] clk_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [4*NREG-1:0]          iomode;
        logic [CNT_W-1:0]           count;
        logic [NREG-1:0]            flags;
        logic                       ovf;
        logic [NREG-1:0][CNT_W-1:0] gr;
        logic [NREG-1:0]            wave;
    } state_t;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 3'd0, A_MODE = 3'd1, A_CNT = 3'd2, A_STAT = 3'd3,
        A_GRA  = 3'd4, A_GRB  = 3'd5, A_GRC = 3'd6, A_GRD = 3'd7
    } addr_e;
endpackage

// File: rtl/bct_prescale.sv
module bct_prescale #(
    parameter int SEL_W = 3,
    localparam int DIV_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [DIV_W-1:0] div_d, div_q;
    logic [DIV_W:0]   mask_w;
    logic [DIV_W-1:0] mask;

    always_comb begin
        div_d  = div_q + 1'b1;
        mask_w = ({{DIV_W{1'b0}}, 1'b1} << sel) - 1'b1;
        mask   = mask_w[DIV_W-1:0];
        tick   = en && ((div_q & mask) == mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/bct_edge_det.sv
module bct_edge_det (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    output logic       event_o
);
    logic [2:0] sh_d, sh_q;
    logic       rise, fall;

    always_comb begin
        sh_d    = {sh_q[1:0], pin};
        rise    = sh_q[1] && !sh_q[2];
        fall    = !sh_q[1] && sh_q[2];
        event_o = (mode[0] && rise) || (mode[1] && fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/bct_timer.sv
module bct_timer
    import bct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic [NREG-1:0]   cap_in,
    output logic [NREG-1:0]   wave_out
);
    state_t st_d, st_q;

    logic            tick;
    logic [NREG-1:0] edge_ev, active, is_cap, match, cap_evt, evt;
    logic [1:0]      buf_en;
    logic [2:0]      clr_sel;
    logic [1:0]      clr_idx;
    logic            clr_evt;

    logic [CNT_W-1:0]           cnt_now;
    logic [NREG-1:0][CNT_W-1:0] gr_now;
    logic                       buf_ac_now, pwm_now, ovf_now;

    bct_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(st_q.ctrl.run),
        .sel(st_q.ctrl.clk_sel), .tick(tick)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_edge
        bct_edge_det u_edge (
            .clk(clk), .rst_n(rst_n), .pin(cap_in[g]),
            .mode(st_q.iomode[4*g +: 2]), .event_o(edge_ev[g])
        );
    end

    always_comb begin
        st_d    = st_q;
        buf_en  = {st_q.ctrl.buf_bd, st_q.ctrl.buf_ac};
        for (int i = 0; i < NREG; i++) begin
            active[i]  = !(i >= 2 && buf_en[i-2]);
            is_cap[i]  = active[i] && !st_q.ctrl.pwm && st_q.iomode[4*i+3];
            match[i]   = tick && active[i] && !is_cap[i] && (st_q.count == st_q.gr[i]);
            cap_evt[i] = is_cap[i] && edge_ev[i];
        end
        evt = match | cap_evt;

        // counter and clear source
        clr_sel = st_q.ctrl.pwm ? 3'd1 : st_q.ctrl.clr_src;
        clr_idx = clr_sel[1:0] - 2'd1;
        clr_evt = (clr_sel != 3'd0) && (clr_sel <= 3'd4) && evt[clr_idx];
        if (clr_evt)   st_d.count = '0;
        else if (tick) st_d.count = st_q.count + 1'b1;
        if (tick && (&st_q.count) && !clr_evt) st_d.ovf = 1'b1;

        // general registers: capture, buffered capture, buffered compare
        for (int i = 0; i < NREG; i++) begin
            if (cap_evt[i]) st_d.gr[i] = st_q.count;
        end
        for (int i = 0; i < 2; i++) begin
            if (buf_en[i] && cap_evt[i]) st_d.gr[i+2] = st_q.gr[i];
            if (buf_en[i] && match[i])   st_d.gr[i]   = st_q.gr[i+2];
        end

        // waveform outputs
        for (int i = 0; i < NREG; i++) begin
            if (st_q.ctrl.pwm) begin
                if (i == 0)        st_d.wave[i] = 1'b0;
                else if (match[0]) st_d.wave[i] = 1'b1;
                else if (match[i]) st_d.wave[i] = 1'b0;
            end else if (match[i]) begin
                case (st_q.iomode[4*i +: 2])
                    2'd1:    st_d.wave[i] = 1'b0;
                    2'd2:    st_d.wave[i] = 1'b1;
                    2'd3:    st_d.wave[i] = !st_q.wave[i];
                    default: st_d.wave[i] = st_q.wave[i];
                endcase
            end
        end

        // flags: write-one-to-clear, event wins
        if (bus_we && bus_addr == A_STAT) begin
            st_d.flags = st_q.flags & ~bus_wdata[NREG-1:0];
            st_d.ovf   = st_q.ovf & ~bus_wdata[NREG];
            if (tick && (&st_q.count) && !clr_evt) st_d.ovf = 1'b1;
        end
        st_d.flags = st_d.flags | evt;

        // bus writes take priority over hardware
        if (bus_we) begin
            case (bus_addr)
                A_CTRL:  st_d.ctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
                A_MODE:  st_d.iomode = bus_wdata[4*NREG-1:0];
                A_CNT:   st_d.count  = bus_wdata;
                A_GRA:   st_d.gr[0]  = bus_wdata;
                A_GRB:   st_d.gr[1]  = bus_wdata;
                A_GRC:   st_d.gr[2]  = bus_wdata;
                A_GRD:   st_d.gr[3]  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, st_q.ctrl};
            A_MODE:  bus_rdata = st_q.iomode;
            A_CNT:   bus_rdata = st_q.count;
            A_STAT:  bus_rdata = {{(CNT_W-NREG-1){1'b0}}, st_q.ovf, st_q.flags};
            A_GRA:   bus_rdata = st_q.gr[0];
            A_GRB:   bus_rdata = st_q.gr[1];
            A_GRC:   bus_rdata = st_q.gr[2];
            default: bus_rdata = st_q.gr[3];
        endcase
    end

    assign wave_out   = st_q.wave;
    assign cnt_now    = st_q.count;
    assign gr_now     = st_q.gr;
    assign buf_ac_now = st_q.ctrl.buf_ac;
    assign pwm_now    = st_q.ctrl.pwm;
    assign ovf_now    = st_q.ovf;
endmodule

// File: rtl/bct_timer_chk.sv
module bct_timer_chk
    import bct_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       bus_we,
    input logic                       tick,
    input logic                       clr_evt,
    input logic [NREG-1:0]            match,
    input logic [NREG-1:0]            cap_evt,
    input logic [CNT_W-1:0]           count,
    input logic [NREG-1:0][CNT_W-1:0] gr,
    input logic                       buf_ac,
    input logic                       pwm,
    input logic                       ovf,
    input logic [NREG-1:0]            wave
);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !bus_we) |=> (count == '0));

    p_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (&count) && !clr_evt) |=> ovf);

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[0] && !bus_we) |=> (gr[0] == $past(count)));

    p_buf_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_evt[0] && buf_ac && !bus_we) |=> (gr[2] == $past(gr[0])));

    p_buf_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (match[0] && buf_ac && !bus_we) |=> (gr[0] == $past(gr[2])));

    p_pwm_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && $past(pwm)) |-> !wave[0]);
endmodule

bind bct_timer bct_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .tick(tick),
    .clr_evt(clr_evt), .match(match), .cap_evt(cap_evt),
    .count(cnt_now), .gr(gr_now), .buf_ac(buf_ac_now),
    .pwm(pwm_now), .ovf(ovf_now), .wave(wave_out)
);

// File: tb/bct_timer_test.sv
module bct_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [3:0]  cap_in = '0;
    logic [3:0]  wave_out;
    int          n_chk = 0;
    int          n_bad = 0;

    always #5 clk = ~clk;

    bct_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
        .wave_out(wave_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pin(input int i, input logic v);
        @(negedge clk);
        cap_in[i] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] v;
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset register", v, 16'h0);
        end
        chk("R1 reset outputs", {12'h0, wave_out}, 16'h0);
    endtask

    task automatic t_rate;
        logic [15:0] v0, v1;
        wr(3'd2, 16'd10);
        rd(3'd2, v0);
        repeat (6) @(negedge clk);
        rd(3'd2, v1);
        chk("R2 hold when stopped", v1, v0);
        wr(3'd0, 16'h0200);
        rd(3'd2, v0);
        repeat (4) @(negedge clk);
        rd(3'd2, v1);
        chk("R2 divide by 1", v1 - v0, 16'd5);
        wr(3'd0, 16'h0203);
        rd(3'd2, v0);
        repeat (63) @(negedge clk);
        rd(3'd2, v1);
        chk("R2 divide by 8", v1 - v0, 16'd8);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_compare_clear;
        logic [15:0] v;
        wr(3'd1, 16'h0003);
        wr(3'd4, 16'd20);
        wr(3'd2, 16'd18);
        wr(3'd0, 16'h0208);
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h0000);
        chk("R3 toggle on match", {15'h0, wave_out[0]}, 16'h1);
        rd(3'd3, v);
        chk("R3 match flag", {15'h0, v[0]}, 16'h1);
        rd(3'd2, v);
        chk("R7 cleared by A match", {15'h0, (v <= 16'd4)}, 16'h1);
        wr(3'd3, 16'h0001);
        rd(3'd3, v);
        chk("R8 write one clears flag", {15'h0, v[0]}, 16'h0);
    endtask

    task automatic t_out_modes;
        wr(3'd1, 16'h3020);
        wr(3'd5, 16'd5);
        wr(3'd7, 16'd7);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0200);
        repeat (10) @(negedge clk);
        wr(3'd0, 16'h0000);
        chk("R3 set high mode", {15'h0, wave_out[1]}, 16'h1);
        chk("R3 toggle mode D", {15'h0, wave_out[3]}, 16'h1);
        chk("R3 no-change mode A", {15'h0, wave_out[0]}, 16'h1);
        wr(3'd1, 16'h0010);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0200);
        repeat (10) @(negedge clk);
        wr(3'd0, 16'h0000);
        chk("R3 drive low mode", {15'h0, wave_out[1]}, 16'h0);
    endtask

    task automatic t_overflow;
        logic [15:0] v;
        wr(3'd1, 16'h0000);
        wr(3'd3, 16'h001F);
        wr(3'd2, 16'hFFFE);
        wr(3'd0, 16'h0200);
        repeat (3) @(negedge clk);
        wr(3'd0, 16'h0000);
        rd(3'd3, v);
        chk("R6 overflow flag", {15'h0, v[4]}, 16'h1);
        rd(3'd2, v);
        chk("R6 counter wrapped", {15'h0, (v <= 16'd4)}, 16'h1);
    endtask

    task automatic t_capture;
        logic [15:0] v;
        wr(3'd1, 16'h0090);
        wr(3'd2, 16'h1234);
        pin(1, 1'b1);
        rd(3'd5, v);
        chk("R5 rising capture", v, 16'h1234);
        rd(3'd3, v);
        chk("R5 capture flag", {15'h0, v[1]}, 16'h1);
        wr(3'd1, 16'h00A0);
        wr(3'd2, 16'h2222);
        pin(1, 1'b0);
        rd(3'd5, v);
        chk("R4 falling capture", v, 16'h2222);
        wr(3'd2, 16'h3333);
        pin(1, 1'b1);
        rd(3'd5, v);
        chk("R4 rising edge ignored", v, 16'h2222);
    endtask

    task automatic t_cap_clear;
        logic [15:0] v;
        wr(3'd1, 16'h0090);
        pin(1, 1'b0);
        wr(3'd0, 16'h0010);
        wr(3'd2, 16'h0500);
        pin(1, 1'b1);
        rd(3'd5, v);
        chk("R7 capture value", v, 16'h0500);
        rd(3'd2, v);
        chk("R7 cleared by B capture", v, 16'h0000);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_buf_capture;
        logic [15:0] v;
        wr(3'd1, 16'h000B);
        wr(3'd0, 16'h0040);
        wr(3'd2, 16'h0100);
        pin(0, 1'b1);
        wr(3'd2, 16'h0200);
        pin(0, 1'b0);
        rd(3'd4, v);
        chk("R9 newest capture in A", v, 16'h0200);
        rd(3'd6, v);
        chk("R9 previous capture in C", v, 16'h0100);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_buf_compare;
        logic [15:0] v;
        wr(3'd1, 16'h0000);
        wr(3'd0, 16'h0040);
        wr(3'd6, 16'd30);
        wr(3'd4, 16'd10);
        rd(3'd4, v);
        chk("R12 register write", v, 16'd10);
        wr(3'd2, 16'd8);
        wr(3'd0, 16'h0240);
        repeat (5) @(negedge clk);
        wr(3'd0, 16'h0040);
        rd(3'd4, v);
        chk("R10 A reloaded from C", v, 16'd30);
        wr(3'd0, 16'h0000);
    endtask

    task automatic t_pwm;
        int highs = 0;
        wr(3'd4, 16'd9);
        wr(3'd5, 16'd3);
        wr(3'd2, 16'd0);
        wr(3'd0, 16'h0300);
        repeat (15) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (wave_out[1]) highs++;
        end
        chk("R11 duty high count", 16'(highs), 16'd8);
        chk("R11 output 0 low", {15'h0, wave_out[0]}, 16'h0);
        wr(3'd0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rate();
        t_compare_clear();
        t_out_modes();
        t_overflow();
        t_capture();
        t_cap_clear();
        t_buf_capture();
        t_buf_compare();
        t_pwm();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule